// File: doc/BRIEF.md
# Configurable FSM State-Sequencing Slice

This block is the clocked part of a reconfigurable state-machine fabric. It holds a `STATE_W`-bit state code and updates it on every rising clock edge. Its output goes to the surrounding combinational logic blocks and also feeds back into this slice. A serial configuration word, loaded while `cfg_en` is high, sets how the next state is formed. Two modes are available.

In counter mode, an incrementer/decrementer moves the state one step around a closed cycle of codes from 0 to a configured last code, in the configured direction. A step happens only when a selected enable is true. The enable comes either from one primary input or from the first logic output. Counter mode suits state machines whose transition graph is a single ring, and with the default 16-bit width it can sequence up to 65536 states. In logic mode, every state bit is loaded from its own sum-of-products function. The literals of those functions are the primary inputs and the low `FB_W` state bits. This mode covers transitions that a counter cannot express. Configuration chains can be linked through `cfg_sdo` when several slices form one machine.

Top module: `fsm_seq_slice`

## Requirements
- R1: A clock edge with `rst` high loads the configured initial code (configuration bits 21:6) into `state`. Reset takes priority over every other action.
- R2: While `cfg_en` is high, each edge shifts `cfg_sdi` into the top of the configuration word and `state` holds. A vector whose bit i is shifted in at the i-th edge ends with bit i at position i. `cfg_sdo` always presents bit 0. Control field positions: bit 0 mode (0 counter, 1 logic), bit 1 direction (0 up, 1 down), bit 2 enable source, bits 5:3 enable input index, bits 21:6 initial code, bits 37:22 last code.
- R3: In counter mode with direction up and the enable true, the next state is state+1. When the state is already at or above the last code, the next state is 0.
- R4: In counter mode with direction down and the enable true, the next state is state-1. When the state is 0 or above the last code, the next state is the last code.
- R5: In counter mode with the enable false, `state` holds.
- R6: With enable source 0, the enable is `din[index]`. With enable source 1, the enable is the logic function of state bit 0, and `din[index]` has no effect.
- R7: In logic mode, next-state bit b is the OR of its PT_N product terms. Term t of bit b starts at configuration bit 38+(b*PT_N+t)*33. Within a term, bits 15:0 are the care mask, bits 31:16 the required literal values, and bit 32 the term enable. A term is true when it is enabled and every cared literal equals its required value. Literal k is `din[k]` for k<8 and `state[k-8]` for k>=8.
- R8: In logic mode, the counter direction, last code and enable have no effect on the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FSM clock, rising edge |
| rst | input | 1 | Synchronous reset to the configured initial code |
| din | input | IN_W | Primary inputs |
| cfg_en | input | 1 | Configuration shift enable; state holds while high |
| cfg_sdi | input | 1 | Serial configuration data in |
| cfg_sdo | output | 1 | Serial configuration data out (bit 0 of the word) |
| state | output | STATE_W | Current state code |

## Verification
Every state result is due after exactly one rising edge: the register that holds `state` is the only one on the path from `din`, the enable and the mode. The bench therefore drives inputs at a falling edge and compares `state` at the next falling edge. A configuration takes effect only after all of its bits have been shifted in. Each scenario is loaded with `rst` held high, and the initial code is checked one edge after the shift ends. `cfg_sdo` is read after that same final shift edge.

// File: rtl/fsm_seq_pkg.sv
package fsm_seq_pkg;
   typedef enum logic {
      NS_COUNT = 1'b0,
      NS_LOGIC = 1'b1
   } ns_mode_e;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } step_dir_e;
endpackage

// File: rtl/fsm_seq_cfg_chain.sv
module fsm_seq_cfg_chain #(
   parameter int CFG_W = 64
) (
   input  logic             clk,
   input  logic             shift_en,
   input  logic             sdi,
   output logic [CFG_W-1:0] cfg_q,
   output logic             sdo
);
   // The newest bit enters at the top; the oldest leaves at bit 0.
   always_ff @(posedge clk) begin
      if (shift_en) cfg_q <= {sdi, cfg_q[CFG_W-1:1]};
   end

   assign sdo = cfg_q[0];
endmodule

// File: rtl/fsm_seq_step.sv
module fsm_seq_step
   import fsm_seq_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] last,
   input  step_dir_e    dir,
   output logic [W-1:0] nxt
);
   // The ring is 0..last. A code outside it re-enters at the ring's start.
   always_comb begin
      if (dir == DIR_UP) begin
         nxt = (cur >= last) ? '0 : cur + W'(1);
      end else begin
         nxt = ((cur == '0) || (cur > last)) ? last : cur - W'(1);
      end
   end
endmodule

// File: rtl/fsm_seq_sop.sv
module fsm_seq_sop #(
   parameter int LIT_W = 16,
   parameter int OUT_W = 16,
   parameter int PT_N  = 2,
   localparam int TERM_W = 2 * LIT_W + 1,
   localparam int ARR_W  = OUT_W * PT_N * TERM_W
) (
   input  logic [LIT_W-1:0] lits,
   input  logic [ARR_W-1:0] term_cfg,
   output logic [OUT_W-1:0] sum
);
   logic [OUT_W-1:0][PT_N-1:0] hit;

   for (genvar b = 0; b < OUT_W; b++) begin : g_bit
      for (genvar t = 0; t < PT_N; t++) begin : g_term
         localparam int BASE = (b * PT_N + t) * TERM_W;
         logic [LIT_W-1:0] care;
         logic [LIT_W-1:0] want;
         logic             on;
         assign care = term_cfg[BASE +: LIT_W];
         assign want = term_cfg[BASE + LIT_W +: LIT_W];
         assign on   = term_cfg[BASE + 2 * LIT_W];
         assign hit[b][t] = on & (&((lits ~^ want) | ~care));
      end
      assign sum[b] = |hit[b];
   end
endmodule

// File: rtl/fsm_seq_slice.sv
module fsm_seq_slice
   import fsm_seq_pkg::*;
#(
   parameter int IN_W    = 8,
   parameter int STATE_W = 16,
   parameter int FB_W    = 8,
   parameter int PT_N    = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [IN_W-1:0]    din,
   input  logic               cfg_en,
   input  logic               cfg_sdi,
   output logic               cfg_sdo,
   output logic [STATE_W-1:0] state
);
   localparam int IDX_W    = $clog2(IN_W);
   localparam int LIT_W    = IN_W + FB_W;
   localparam int TERM_W   = 2 * LIT_W + 1;
   localparam int OFF_MODE = 0;
   localparam int OFF_DIR  = 1;
   localparam int OFF_ESRC = 2;
   localparam int OFF_EIDX = 3;
   localparam int OFF_INIT = OFF_EIDX + IDX_W;
   localparam int OFF_LAST = OFF_INIT + STATE_W;
   localparam int CTRL_W   = OFF_LAST + STATE_W;
   localparam int TERMS_W  = STATE_W * PT_N * TERM_W;
   localparam int CFG_W    = CTRL_W + TERMS_W;

   if (IN_W < 2 || IN_W > 8) begin : g_bad_in
      $error("fsm_seq_slice: IN_W must be within 2..8");
   end
   if (FB_W < 1 || FB_W > STATE_W) begin : g_bad_fb
      $error("fsm_seq_slice: FB_W must be within 1..STATE_W");
   end
   if (PT_N < 1) begin : g_bad_pt
      $error("fsm_seq_slice: PT_N must be at least 1");
   end

   logic [CFG_W-1:0]   cfg_q;
   ns_mode_e           mode_f;
   step_dir_e          dir_f;
   logic               esrc_f;
   logic [IDX_W-1:0]   eidx_f;
   logic [STATE_W-1:0] init_f;
   logic [STATE_W-1:0] last_f;
   logic [STATE_W-1:0] state_q;
   logic [STATE_W-1:0] step_nxt;
   logic [STATE_W-1:0] sop_nxt;
   logic [LIT_W-1:0]   lits;
   logic               step_en;

   fsm_seq_cfg_chain #(.CFG_W(CFG_W)) u_chain (
      .clk      (clk),
      .shift_en (cfg_en),
      .sdi      (cfg_sdi),
      .cfg_q    (cfg_q),
      .sdo      (cfg_sdo)
   );

   assign mode_f = ns_mode_e'(cfg_q[OFF_MODE]);
   assign dir_f  = step_dir_e'(cfg_q[OFF_DIR]);
   assign esrc_f = cfg_q[OFF_ESRC];
   assign eidx_f = cfg_q[OFF_EIDX +: IDX_W];
   assign init_f = cfg_q[OFF_INIT +: STATE_W];
   assign last_f = cfg_q[OFF_LAST +: STATE_W];

   assign lits = {state_q[FB_W-1:0], din};

   fsm_seq_sop #(.LIT_W(LIT_W), .OUT_W(STATE_W), .PT_N(PT_N)) u_sop (
      .lits     (lits),
      .term_cfg (cfg_q[CFG_W-1:CTRL_W]),
      .sum      (sop_nxt)
   );

   fsm_seq_step #(.W(STATE_W)) u_step (
      .cur  (state_q),
      .last (last_f),
      .dir  (dir_f),
      .nxt  (step_nxt)
   );

   assign step_en = esrc_f ? sop_nxt[0] : din[eidx_f];

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= init_f;
      end else if (!cfg_en) begin
         if (mode_f == NS_LOGIC) state_q <= sop_nxt;
         else if (step_en)       state_q <= step_nxt;
      end
   end

   assign state = state_q;
endmodule

// File: rtl/fsm_seq_slice_chk.sv
module fsm_seq_slice_chk #(
   parameter int STATE_W = 16
) (
   input logic               clk,
   input logic               rst,
   input logic               cfg_en,
   input logic               mode,
   input logic               dir,
   input logic               step_en,
   input logic [STATE_W-1:0] state,
   input logic [STATE_W-1:0] init,
   input logic [STATE_W-1:0] last
);
   logic cnt_go;
   assign cnt_go = !cfg_en && !mode && step_en;

   a_r1_reset_init: assert property (@(posedge clk)
      rst |=> state == $past(init));

   a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
      cfg_en |=> $stable(state));

   a_r3_up_step: assert property (@(posedge clk) disable iff (rst)
      (cnt_go && !dir && state < last) |=> state == $past(state) + STATE_W'(1));

   a_r3_up_wrap: assert property (@(posedge clk) disable iff (rst)
      (cnt_go && !dir && state >= last) |=> state == '0);

   a_r4_down_step: assert property (@(posedge clk) disable iff (rst)
      (cnt_go && dir && state != '0 && state <= last) |=> state == $past(state) - STATE_W'(1));

   a_r4_down_wrap: assert property (@(posedge clk) disable iff (rst)
      (cnt_go && dir && (state == '0 || state > last)) |=> state == $past(last));

   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      (!cfg_en && !mode && !step_en) |=> $stable(state));
endmodule

bind fsm_seq_slice fsm_seq_slice_chk #(.STATE_W(STATE_W)) chk_i (
   .clk     (clk),
   .rst     (rst),
   .cfg_en  (cfg_en),
   .mode    (cfg_q[OFF_MODE]),
   .dir     (cfg_q[OFF_DIR]),
   .step_en (step_en),
   .state   (state_q),
   .init    (init_f),
   .last    (last_f)
);

// File: tb/fsm_seq_slice_tb.sv
module fsm_seq_slice_tb_top;
   localparam int CLK_P   = 10;
   localparam int IN_W    = 8;
   localparam int STATE_W = 16;
   localparam int FB_W    = 8;
   localparam int PT_N    = 2;
   localparam int LIT_W   = IN_W + FB_W;
   localparam int TERM_W  = 2 * LIT_W + 1;
   localparam int CTRL_W  = 38;
   localparam int CFG_W   = CTRL_W + STATE_W * PT_N * TERM_W;

   // Table row: {dir, init, last}
   localparam logic [32:0] TBL [6] = '{
      {1'b0, 16'h0000, 16'h0003},
      {1'b0, 16'h0007, 16'h0009},
      {1'b1, 16'h0002, 16'h0004},
      {1'b1, 16'h0000, 16'h0005},
      {1'b0, 16'hFFFD, 16'hFFFF},
      {1'b1, 16'h0001, 16'hFFFF}
   };

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic [IN_W-1:0]    din = '0;
   logic               cfg_en = 1'b0;
   logic               cfg_sdi = 1'b0;
   logic               cfg_sdo;
   logic [STATE_W-1:0] state;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_P / 2) clk = ~clk;

   fsm_seq_slice #(.IN_W(IN_W), .STATE_W(STATE_W), .FB_W(FB_W), .PT_N(PT_N)) dut_i (
      .clk(clk), .rst(rst), .din(din), .cfg_en(cfg_en),
      .cfg_sdi(cfg_sdi), .cfg_sdo(cfg_sdo), .state(state)
   );

   function automatic logic [CFG_W-1:0] mk_ctrl(input logic mode, input logic dir,
         input logic esrc, input logic [2:0] eidx, input logic [15:0] init,
         input logic [15:0] last);
      logic [CFG_W-1:0] v = '0;
      v[0] = mode; v[1] = dir; v[2] = esrc;
      v[5:3] = eidx; v[21:6] = init; v[37:22] = last;
      return v;
   endfunction

   function automatic logic [CFG_W-1:0] set_term(input logic [CFG_W-1:0] v, input int b,
         input int t, input logic [LIT_W-1:0] care, input logic [LIT_W-1:0] want);
      int off = CTRL_W + (b * PT_N + t) * TERM_W;
      v[off +: LIT_W] = care;
      v[off + LIT_W +: LIT_W] = want;
      v[off + 2 * LIT_W] = 1'b1;
      return v;
   endfunction

   function automatic logic [15:0] exp_logic(input logic [CFG_W-1:0] v,
         input logic [IN_W-1:0] d, input logic [15:0] s);
      logic [15:0] r = '0;
      logic [LIT_W-1:0] l = {s[FB_W-1:0], d};
      for (int b = 0; b < STATE_W; b++) begin
         for (int t = 0; t < PT_N; t++) begin
            int off = CTRL_W + (b * PT_N + t) * TERM_W;
            logic [LIT_W-1:0] c = v[off +: LIT_W];
            logic [LIT_W-1:0] w = v[off + LIT_W +: LIT_W];
            if (v[off + 2 * LIT_W] && ((l & c) == (w & c))) r[b] = 1'b1;
         end
      end
      return r;
   endfunction

   function automatic logic [15:0] exp_step(input logic [15:0] s, input logic [15:0] last,
         input logic dir);
      if (!dir) return (s >= last) ? 16'h0 : s + 16'h1;
      return (s == 16'h0 || s > last) ? last : s - 16'h1;
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Starts and ends at a falling edge; the caller sets rst.
   task automatic load_cfg(input logic [CFG_W-1:0] v);
      for (int i = 0; i < CFG_W; i++) begin
         cfg_en = 1'b1; cfg_sdi = v[i];
         @(negedge clk);
      end
      cfg_en = 1'b0;
   endtask

   // Loads with reset held, then releases reset after the initial code is loaded.
   task automatic setup(input logic [CFG_W-1:0] v, input string tag);
      rst = 1'b1;
      load_cfg(v);
      check({tag, " R2 sdo"}, {15'h0, cfg_sdo}, {15'h0, v[0]});
      @(negedge clk);
      check({tag, " R1 init"}, state, v[21:6]);
      rst = 1'b0;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [CFG_W-1:0] v;
      logic [15:0] e;
      logic [15:0] s;
      @(negedge clk);

      // Table walk: counter rings in both directions (R1, R3, R4)
      for (int r = 0; r < 6; r++) begin
         v = mk_ctrl(1'b0, TBL[r][32], 1'b0, 3'd0, TBL[r][31:16], TBL[r][15:0]);
         setup(v, "tbl");
         din = 8'h01;
         e = TBL[r][31:16];
         for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            e = exp_step(e, TBL[r][15:0], TBL[r][32]);
            check(TBL[r][32] ? "R4 ring down" : "R3 ring up", state, e);
         end
      end

      // R5 and R6: enable from din[5]; a low enable holds
      v = mk_ctrl(1'b0, 1'b0, 1'b0, 3'd5, 16'd10, 16'd50);
      setup(v, "en");
      din = 8'h20; @(negedge clk); check("R6 din idx step", state, 16'd11);
      din = 8'hDF; @(negedge clk); check("R5 enable low holds", state, 16'd11);
      din = 8'h20; @(negedge clk); check("R3 step again", state, 16'd12);

      // R6: enable from logic bit 0, whose term requires din[3]=1
      v = mk_ctrl(1'b0, 1'b0, 1'b1, 3'd0, 16'd5, 16'd100);
      v = set_term(v, 0, 0, 16'h0008, 16'h0008);
      setup(v, "lsrc");
      din = 8'h08; @(negedge clk); check("R6 logic enable step", state, 16'd6);
      din = 8'h01; @(negedge clk); check("R6 din idx ignored", state, 16'd6);
      din = 8'h08; @(negedge clk); check("R6 logic enable step2", state, 16'd7);

      // R3/R4: initial code beyond last code
      v = mk_ctrl(1'b0, 1'b0, 1'b0, 3'd0, 16'd20, 16'd9);
      setup(v, "oor");
      din = 8'h01; @(negedge clk); check("R3 above last -> 0", state, 16'd0);
      v = mk_ctrl(1'b0, 1'b1, 1'b0, 3'd0, 16'd20, 16'd9);
      setup(v, "oor");
      din = 8'h01; @(negedge clk); check("R4 above last -> last", state, 16'd9);

      // R7 and R8: logic mode
      v = mk_ctrl(1'b1, 1'b1, 1'b0, 3'd0, 16'h00F0, 16'd3);
      v = set_term(v, 0, 0, 16'h0001, 16'h0001);
      v = set_term(v, 1, 0, 16'h0102, 16'h0100);
      v = set_term(v, 1, 1, 16'h0004, 16'h0004);
      v = set_term(v, 2, 0, 16'h0000, 16'h0000);
      v = set_term(v, 9, 1, 16'h0030, 16'h0010);
      setup(v, "logic");
      e = 16'h00F0;
      for (int k = 0; k < 8; k++) begin
         din = 8'((k * 37) ^ 8'h11);
         e = exp_logic(v, din, e);
         @(negedge clk);
         check("R7 sop next state", state, e);
      end
      din = 8'h00; e = exp_logic(v, din, e);
      @(negedge clk); check("R8 enable/dir ignored", state, e);

      // R2: state holds across a reload; the new configuration then applies
      v = mk_ctrl(1'b0, 1'b0, 1'b0, 3'd0, 16'd0, 16'd1000);
      setup(v, "hold");
      din = 8'h01;
      repeat (4) @(negedge clk);
      s = state;
      check("R3 run before reload", s, 16'd4);
      v = mk_ctrl(1'b0, 1'b1, 1'b0, 3'd0, 16'd0, 16'd1000);
      load_cfg(v);
      check("R2 held during config", state, s);
      @(negedge clk); check("R4 new config applies", state, s - 16'd1);

      // R1: reset mid-run reloads the initial code
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      check("R1 reset mid-run", state, 16'd0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule